// File: doc/BRIEF.md
# Unsigned Difference with Sign-and-Magnitude Output

This block takes two unsigned words of equal width, a minuend and a subtrahend, and returns the distance between them as an unsigned magnitude together with a flag that says whether the true difference is below zero. Inside, the subtrahend is inverted and added to the minuend with a carry-in of one. The carry that leaves the top bit then decides the result. When that carry is set, the sum is already the difference. When it is clear, the sum is converted back into a magnitude by inverting it and adding one.

The block is purely combinational and has no clock or reset. A surrounding pipeline registers its operands and results wherever its timing requires. The width is a parameter and defaults to 8 bits. The magnitude always fits in the same number of bits as the operands, so the result never overflows.

Top module: `usub_magnitude`

## Requirements
- R1: When the minuend is greater than the subtrahend, `neg_o` is 0 and `mag_o` equals minuend minus subtrahend.
- R2: When the minuend is less than the subtrahend, `neg_o` is 1 and `mag_o` equals subtrahend minus minuend.
- R3: When both operands are equal, `mag_o` is 0 and `neg_o` is 0. A negative zero is never produced.
- R4: With WIDTH=8, minuend 8'h54 and subtrahend 8'h43 give `mag_o` = 8'h11 and `neg_o` = 0.
- R5: With WIDTH=8, minuend 8'h43 and subtrahend 8'h54 give `mag_o` = 8'h11 and `neg_o` = 1.
- R6: At the range limits the magnitude is exact. Minuend 0 with subtrahend all ones gives `mag_o` = all ones and `neg_o` = 1. The reverse pair gives all ones and `neg_o` = 0. Whenever `neg_o` is 1, `mag_o` is non-zero.
- R7: The function holds for any WIDTH, including WIDTH=4, and the outputs follow a change of input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| minuend_i | input | WIDTH | Unsigned value to subtract from |
| subtrahend_i | input | WIDTH | Unsigned value being subtracted |
| mag_o | output | WIDTH | Absolute value of the difference |
| neg_o | output | 1 | Set when the true difference is negative |

## Verification
Both results are due in the same cycle as their operands, because no register lies between any input and either output. The bench changes operands on the falling clock edge and samples 2 ns later, which is well inside the low phase of the clock. Each sample therefore sees the settled response to exactly one operand pair. Every operand pair is swept at 8 bits and again at 4 bits, and each result is compared with integer subtraction and an absolute-value reference.

// File: rtl/usub_pkg.sv
package usub_pkg;
  parameter int unsigned USUB_DEF_WIDTH = 8;

  typedef enum logic {
    SIGN_POS = 1'b0,
    SIGN_NEG = 1'b1
  } usub_sign_e;
endpackage

// File: rtl/usub_fa_cell.sv
module usub_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic gen_w;
  logic prop_w;

  // Generate and propagate terms of one bit position.
  assign gen_w  = a_i & b_i;
  assign prop_w = a_i ^ b_i;
  assign s_o    = prop_w ^ c_i;
  assign c_o    = gen_w | (prop_w & c_i);
endmodule

// File: rtl/usub_ripple_add.sv
module usub_ripple_add #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] chain_w;

  assign chain_w[0] = cin_i;

  // One full-adder cell per bit; the carry of cell k feeds cell k+1.
  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    usub_fa_cell fa_i (
      .a_i (a_i[k]),
      .b_i (b_i[k]),
      .c_i (chain_w[k]),
      .s_o (sum_o[k]),
      .c_o (chain_w[k+1])
    );
  end

  assign cout_o = chain_w[WIDTH];
endmodule

// File: rtl/usub_cond_negate.sv
module usub_cond_negate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             flip_i,
  output logic [WIDTH-1:0] val_o
);
  logic [WIDTH-1:0] inv_w;
  logic [WIDTH-1:0] inc_w;

  // When flip_i is set, invert the value and add one through a half-adder
  // chain; when it is clear the chain receives no carry and passes through.
  assign inv_w    = val_i ^ {WIDTH{flip_i}};
  assign inc_w[0] = flip_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_inc
    assign val_o[k] = inv_w[k] ^ inc_w[k];
    if (k < WIDTH - 1) begin : g_carry
      assign inc_w[k+1] = inv_w[k] & inc_w[k];
    end
  end
endmodule

// File: rtl/usub_magnitude.sv
module usub_magnitude
  import usub_pkg::*;
#(
  parameter int unsigned WIDTH = USUB_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] minuend_i,
  input  logic [WIDTH-1:0] subtrahend_i,
  output logic [WIDTH-1:0] mag_o,
  output logic             neg_o
);
  logic [WIDTH-1:0] raw_w;
  logic             end_carry_w;
  usub_sign_e       sign_w;

  // Raw sum: M + ~N + 1, which equals M + (2^WIDTH - N).
  usub_ripple_add #(.WIDTH(WIDTH)) add_i (
    .a_i    (minuend_i),
    .b_i    (~subtrahend_i),
    .cin_i  (1'b1),
    .sum_o  (raw_w),
    .cout_o (end_carry_w)
  );

  // A missing end carry means the minuend was smaller.
  assign sign_w = end_carry_w ? SIGN_POS : SIGN_NEG;

  usub_cond_negate #(.WIDTH(WIDTH)) neg_i (
    .val_i  (raw_w),
    .flip_i (sign_w == SIGN_NEG),
    .val_o  (mag_o)
  );

  assign neg_o = (sign_w == SIGN_NEG);
endmodule

// File: rtl/usub_magnitude_chk.sv
module usub_magnitude_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] minuend_i,
  input logic [WIDTH-1:0] subtrahend_i,
  input logic [WIDTH-1:0] mag_o,
  input logic             neg_o
);
  always_comb begin
    if (minuend_i > subtrahend_i)
      a_r1_pos_diff: assert (!neg_o && mag_o == WIDTH'(minuend_i - subtrahend_i));
    if (minuend_i < subtrahend_i)
      a_r2_neg_diff: assert (neg_o && mag_o == WIDTH'(subtrahend_i - minuend_i));
    if (minuend_i == subtrahend_i)
      a_r3_no_neg_zero: assert (!neg_o && mag_o == '0);
    if (neg_o)
      a_r6_neg_nonzero: assert (mag_o != '0);
  end
endmodule

bind usub_magnitude usub_magnitude_chk #(.WIDTH(WIDTH)) chk_i (
  .minuend_i    (minuend_i),
  .subtrahend_i (subtrahend_i),
  .mag_o        (mag_o),
  .neg_o        (neg_o)
);

// File: tb/usub_magnitude_tb_top.sv
`timescale 1ns/1ps
module usub_magnitude_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [7:0] m8, s8, mag8;
  logic       neg8;
  logic [3:0] m4, s4, mag4;
  logic       neg4;

  usub_magnitude #(.WIDTH(8)) dut_i (
    .minuend_i(m8), .subtrahend_i(s8), .mag_o(mag8), .neg_o(neg8));

  usub_magnitude #(.WIDTH(4)) dut_w4_i (
    .minuend_i(m4), .subtrahend_i(s4), .mag_o(mag4), .neg_o(neg4));

  task automatic check(string req, int act_mag, int act_neg, int exp_mag, int exp_neg);
    n_checks++;
    if (act_mag != exp_mag || act_neg != exp_neg) begin
      n_errors++;
      $display("FAIL %s: mag=%0d neg=%0d expected mag=%0d neg=%0d",
               req, act_mag, act_neg, exp_mag, exp_neg);
    end
  endtask

  function automatic string tag_of(int a, int b);
    if (a == b) return "R3";
    if (a > b) return "R1";
    return "R2";
  endfunction

  task automatic apply8(int a, int b, string req);
    @(negedge clk);
    m8 = a[7:0]; s8 = b[7:0];
    #2;
    check(req, int'(mag8), int'(neg8), (a >= b) ? a - b : b - a, (a < b) ? 1 : 0);
  endtask

  initial begin
    m8 = '0; s8 = '0; m4 = '0; s4 = '0;
    #2;
    check("R3 initial zero operands", int'(mag8), int'(neg8), 0, 0);
    apply8(8'h54, 8'h43, "R4");
    apply8(8'h43, 8'h54, "R5");
    apply8(0, 255, "R6");
    apply8(255, 0, "R6");
    apply8(255, 255, "R3");
    // Full 8-bit sweep against integer subtraction and absolute value.
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply8(a, b, tag_of(a, b));
    // R7: full sweep of a 4-bit instance.
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        m4 = a[3:0]; s4 = b[3:0];
        #2;
        check("R7", int'(mag4), int'(neg4), (a >= b) ? a - b : b - a, (a < b) ? 1 : 0);
      end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule